// File: doc/BRIEF.md
# Serial CRC-32 Engine

This block divides a serial bit stream by the 32-bit generator polynomial 0x04C11DB7, one bit per clock. It produces the CRC that a transmitter appends to a frame. It also checks a received frame, where the message and its appended CRC go through the same division. Each incoming bit is folded into the remainder at the point where the reduction decision is made. The engine therefore never spends cycles on leading or trailing zero padding.

A frame opens with a start strobe. That strobe presets the remainder to all ones and captures the bit order for the frame: most-significant-first with a left shift, or least-significant-first with a right shift and the reflected polynomial. Data bits count only when qualified by a valid strobe.

The running remainder is visible at all times, together with its bitwise inverse, which is the value to transmit. An end-of-frame strobe, raised after the last CRC bit of a received frame, records whether the remainder equals the fixed non-zero residue for the frame's bit order. That verdict stays registered until the next start strobe.

Top module: `crc_serial_engine`

## Requirements
- R1: A start strobe loads the remainder with all ones at the next clock edge. A valid data bit in the same cycle as the start strobe is discarded.
- R2: In most-significant-first order (`lsb_first` = 0 at start), each valid bit is XORed into remainder bit 31. The remainder then shifts left one place and, if the bit shifted out was 1, is XORed with 0x04C11DB7. For the ASCII bytes "123456789", each sent bit 7 first, `crc_tx` ends at 0xFC891918.
- R3: In least-significant-first order (`lsb_first` = 1 at start), each valid bit is XORed into remainder bit 0. The remainder then shifts right one place and, if the bit shifted out was 1, is XORed with 0xEDB88320. Each byte is sent bit 0 first. "123456789" gives `crc_tx` = 0xCBF43926, a single 0x61 byte gives 0xE8B7BE43, and a single 0x00 byte gives 0xD202EF8D.
- R4: While `bit_valid` is low and no start strobe is present, the remainder holds its value whatever `bit_in` does.
- R5: `crc_tx` is always the bitwise inverse of `crc_run`. A frame with no data bits gives `crc_tx` = 0x00000000.
- R6: The bit order is captured only by a start strobe. Changing `lsb_first` in the middle of a frame has no effect on that frame.
- R7: On an end-of-frame strobe without a start strobe, `verdict_valid` goes to 1 at the next edge. `verdict_pass` goes to 1 only if the remainder equals the residue for the frame's order: 0xC704DD7B for most-significant-first, 0xDEBB20E3 for least-significant-first. A valid bit in the same cycle as the end-of-frame strobe is included before the comparison. The transmitted CRC is appended bit 31 first in most-significant-first order and bit 0 first in the other order.
- R8: The verdict outputs hold through later data bits and idle cycles. A start strobe clears both outputs to 0 at the next edge, and it takes priority over an end-of-frame strobe in the same cycle.
- R9: While `rst_n` is low at a clock edge, the remainder becomes all ones, the order becomes most-significant-first, and both verdict outputs become 0.
- R10: Zero bits placed before a message change its CRC. One zero bit appended after a correct message and CRC makes the check fail, and so does a flipped CRC bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a frame: presets the remainder and captures the bit order |
| lsb_first | input | 1 | Bit order captured at start: 1 = least-significant-first, 0 = most-significant-first |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit |
| frame_end | input | 1 | End of a received frame, after its last CRC bit |
| crc_run | output | 32 | Current remainder |
| crc_tx | output | 32 | Inverted remainder, the CRC to transmit |
| verdict_valid | output | 1 | A verdict has been recorded since the last start |
| verdict_pass | output | 1 | The recorded verdict matched the residue |

## Verification
The remainder register drives `crc_run` directly. A wrong shift direction, a wrong polynomial tap or a missed merge of an input bit therefore shows on the port one edge after the faulty bit, and it keeps propagating through every later bit. A wrongly captured bit order shows from the first valid bit after the start strobe, because the known-answer values for the two orders differ completely. A fault in the verdict register shows one edge after the end-of-frame strobe. If a stale verdict survives, it shows one edge after the next start strobe, so the bench samples both outputs at those points as well as after idle stretches.

// File: rtl/crc_ser_pkg.sv
// Package: shared width, bit-order type and a bit-mirroring helper for the
// serial CRC engine. Assumes a 32-bit remainder throughout the block.
package crc_ser_pkg;

    localparam int CRC_W = 32;

    typedef logic [CRC_W-1:0] crc_word_t;

    // Bit order of a frame, captured at the start strobe.
    typedef enum logic {
        ORD_MSB_FIRST = 1'b0,
        ORD_LSB_FIRST = 1'b1
    } bit_order_e;

    // Reverse the bit positions of a remainder-wide word.
    function automatic crc_word_t mirror_word(input crc_word_t v);
        crc_word_t r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_bit_step.sv
// One serial division step, purely combinational.
// SHIFT_RIGHT = 0: the bit is merged into the top bit, the remainder shifts
// left and POLY_K (normal form) is applied when the top bit leaves as 1.
// SHIFT_RIGHT = 1: the bit is merged into bit 0, the remainder shifts right
// and POLY_K (which must be in reflected form) is applied when bit 0 leaves as 1.
// Assumes POLY_K omits the x^CRC_W term.
module crc_bit_step
    import crc_ser_pkg::*;
#(
    parameter bit        SHIFT_RIGHT = 1'b0,
    parameter crc_word_t POLY_K      = 32'h04C11DB7
) (
    input  crc_word_t rem_in,
    input  logic      din,
    output crc_word_t rem_out
);

    localparam crc_word_t ZERO_WORD = '0;

    crc_word_t merged;
    logic      leaving;

    generate
        if (SHIFT_RIGHT) begin : g_right
            // Merge at bit 0, reduce on the bit shifted out to the right.
            always_comb begin
                merged  = rem_in;
                merged[0] = rem_in[0] ^ din;
                leaving = merged[0];
                rem_out = (merged >> 1) ^ (leaving ? POLY_K : ZERO_WORD);
            end
        end else begin : g_left
            // Merge at the top bit, reduce on the bit shifted out to the left.
            always_comb begin
                merged  = rem_in;
                merged[CRC_W-1] = rem_in[CRC_W-1] ^ din;
                leaving = merged[CRC_W-1];
                rem_out = (merged << 1) ^ (leaving ? POLY_K : ZERO_WORD);
            end
        end
    endgenerate

endmodule

// File: rtl/crc_remainder_reg.sv
// Remainder register and frame bit-order register.
// Holds the running remainder, presets it on a start strobe (which wins over
// a same-cycle data bit), advances it one division step per valid bit in the
// order captured at start, and exposes the next-state value for the checker.
// Assumes a synchronous active-low reset.
module crc_remainder_reg
    import crc_ser_pkg::*;
#(
    parameter crc_word_t POLY = 32'h04C11DB7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       order_sel,
    input  logic       bit_valid,
    input  logic       bit_in,
    output crc_word_t  remainder,
    output crc_word_t  rem_next,
    output bit_order_e order_q
);

    localparam crc_word_t SEED      = '1;
    localparam crc_word_t POLY_REFL = mirror_word(POLY);

    crc_word_t step_left;
    crc_word_t step_right;
    crc_word_t step_sel;

    crc_bit_step #(
        .SHIFT_RIGHT(1'b0),
        .POLY_K     (POLY)
    ) u_step_left (
        .rem_in (remainder),
        .din    (bit_in),
        .rem_out(step_left)
    );

    crc_bit_step #(
        .SHIFT_RIGHT(1'b1),
        .POLY_K     (POLY_REFL)
    ) u_step_right (
        .rem_in (remainder),
        .din    (bit_in),
        .rem_out(step_right)
    );

    // Pick the step result that matches the frame's captured order.
    always_comb begin
        step_sel = (order_q == ORD_LSB_FIRST) ? step_right : step_left;
    end

    // Next remainder: start preset first, then a valid bit, else hold.
    always_comb begin
        if (frame_start) begin
            rem_next = SEED;
        end else if (bit_valid) begin
            rem_next = step_sel;
        end else begin
            rem_next = remainder;
        end
    end

    // Remainder register with synchronous reset to the seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remainder <= SEED;
        end else begin
            remainder <= rem_next;
        end
    end

    // Bit-order register, loaded only by a start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORD_MSB_FIRST;
        end else if (frame_start) begin
            order_q <= bit_order_e'(order_sel);
        end
    end

    // R1: the cycle after a start strobe the remainder is all ones.
    p_preset_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (remainder == SEED));

    // R4: with no start and no valid bit the remainder does not move.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !bit_valid) |=> $stable(remainder));

    // R6: the order changes only on a start strobe.
    p_order_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(order_q));

    // R6: a start strobe captures the order input.
    p_order_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (order_q == bit_order_e'($past(order_sel))));

endmodule

// File: rtl/crc_residue_judge.sv
// Receive-side verdict register.
// At an end-of-frame strobe it compares the next-state remainder (so a bit in
// the same cycle counts) against the fixed residue for the frame's order, and
// holds the result until a start strobe clears it. Start wins over end.
// Assumes the residue parameter is given in most-significant-first form; the
// reflected residue is derived by mirroring.
module crc_residue_judge
    import crc_ser_pkg::*;
#(
    parameter crc_word_t RESIDUE = 32'hC704DD7B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       frame_end,
    input  crc_word_t  rem_next,
    input  bit_order_e order_q,
    output logic       verdict_valid,
    output logic       verdict_pass
);

    localparam crc_word_t RESIDUE_REFL = mirror_word(RESIDUE);

    crc_word_t target;
    logic      match;

    // Residue that a correct frame leaves in the chosen order.
    always_comb begin
        target = (order_q == ORD_LSB_FIRST) ? RESIDUE_REFL : RESIDUE;
        match  = (rem_next == target);
    end

    // Verdict register: cleared by start, written by end, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_pass  <= 1'b0;
        end else if (frame_start) begin
            verdict_valid <= 1'b0;
            verdict_pass  <= 1'b0;
        end else if (frame_end) begin
            verdict_valid <= 1'b1;
            verdict_pass  <= match;
        end
    end

    // R8: a start strobe clears both verdict outputs.
    p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!verdict_valid && !verdict_pass));

    // R8: the verdict holds when neither strobe is present.
    p_verdict_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !frame_end) |=> ($stable(verdict_valid) && $stable(verdict_pass)));

    // R7: an end strobe without start produces a recorded verdict.
    p_end_records_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_start) |=> verdict_valid);

    // R7: a pass is only ever reported with a recorded verdict.
    p_pass_implies_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_pass |-> verdict_valid);

endmodule

// File: rtl/crc_serial_engine.sv
// Top level of the serial CRC-32 engine.
// Wires the remainder register (with its two step variants) to the residue
// verdict logic and drives the running and inverted CRC outputs.
// Assumes one bit per clock, strobes one cycle wide, synchronous active-low reset.
module crc_serial_engine
    import crc_ser_pkg::*;
#(
    parameter crc_word_t POLY    = 32'h04C11DB7,
    parameter crc_word_t RESIDUE = 32'hC704DD7B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             lsb_first,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             frame_end,
    output logic [CRC_W-1:0] crc_run,
    output logic [CRC_W-1:0] crc_tx,
    output logic             verdict_valid,
    output logic             verdict_pass
);

    crc_word_t  remainder;
    crc_word_t  rem_next;
    bit_order_e order_q;

    crc_remainder_reg #(
        .POLY(POLY)
    ) u_rem (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .order_sel  (lsb_first),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .remainder  (remainder),
        .rem_next   (rem_next),
        .order_q    (order_q)
    );

    crc_residue_judge #(
        .RESIDUE(RESIDUE)
    ) u_judge (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .rem_next     (rem_next),
        .order_q      (order_q),
        .verdict_valid(verdict_valid),
        .verdict_pass (verdict_pass)
    );

    // Drive the running remainder and its inverse for transmission.
    always_comb begin
        crc_run = remainder;
        crc_tx  = ~remainder;
    end

endmodule

// File: tb/crc_serial_engine_test.sv
`timescale 1ns/1ps
module crc_serial_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        lsb_first = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        frame_end = 1'b0;
    logic [31:0] crc_run;
    logic [31:0] crc_tx;
    logic        verdict_valid;
    logic        verdict_pass;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    crc_serial_engine uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .lsb_first    (lsb_first),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .frame_end    (frame_end),
        .crc_run      (crc_run),
        .crc_tx       (crc_tx),
        .verdict_valid(verdict_valid),
        .verdict_pass (verdict_pass)
    );

    // Known-answer vectors: order (1 = LSB-first), byte count, bytes (byte 0 low), expected crc_tx.
    localparam int NV = 5;
    localparam logic        TV_ORD [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          TV_LEN [NV] = '{9, 9, 1, 1, 0};
    localparam logic [71:0] TV_DAT [NV] = '{72'h393837363534333231, 72'h393837363534333231,
                                            72'h00, 72'h61, 72'h0};
    localparam logic [31:0] TV_EXP [NV] = '{32'hCBF43926, 32'hFC891918, 32'hD202EF8D,
                                            32'hE8B7BE43, 32'h00000000};
    localparam string       TV_REQ [NV] = '{"R3", "R2", "R3", "R3", "R5"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ne(input string req, input logic [31:0] act, input logic [31:0] other);
        n_checks++;
        if (act === other) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected a value other than %h", req, act, other);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic start_frame(input logic ord);
        frame_start = 1'b1;
        lsb_first   = ord;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1;
        bit_in    = b;
        tick();
        bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic ord, input logic [7:0] d);
        for (int i = 0; i < 8; i++) send_bit(ord ? d[i] : d[7-i]);
    endtask

    task automatic send_bytes(input logic ord, input int len, input logic [71:0] d);
        for (int k = 0; k < len; k++) send_byte(ord, d[8*k +: 8]);
    endtask

    task automatic send_crc(input logic ord, input logic [31:0] c);
        for (int i = 0; i < 32; i++) send_bit(ord ? c[i] : c[31-i]);
    endtask

    task automatic end_frame();
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] snap;
        logic [31:0] got;
        repeat (3) tick();
        // R9: reset state
        chk("R9 reset crc_run", crc_run, 32'hFFFFFFFF);
        chk("R9 reset verdict", {30'd0, verdict_valid, verdict_pass}, 32'd0);
        rst_n = 1'b1;
        tick();

        // Table walk: known answers, then the check over message plus CRC (R7).
        for (int v = 0; v < NV; v++) begin
            start_frame(TV_ORD[v]);
            send_bytes(TV_ORD[v], TV_LEN[v], TV_DAT[v]);
            chk(TV_REQ[v], crc_tx, TV_EXP[v]);
            chk("R5 inverse", crc_run, ~TV_EXP[v]);
            send_crc(TV_ORD[v], crc_tx);
            end_frame();
            chk("R7 check passes", {30'd0, verdict_valid, verdict_pass}, 32'd3);
        end

        // R8: verdict held through data bits and idle, then cleared by start.
        send_bit(1'b1);
        send_bit(1'b0);
        repeat (3) tick();
        chk("R8 hold", {30'd0, verdict_valid, verdict_pass}, 32'd3);
        start_frame(1'b1);
        chk("R8 clear on start", {30'd0, verdict_valid, verdict_pass}, 32'd0);

        // R4: invalid bits are ignored.
        send_byte(1'b1, 8'h31);
        snap = crc_run;
        for (int i = 0; i < 6; i++) begin
            bit_in = i[0];
            tick();
        end
        chk("R4 idle hold", crc_run, snap);
        send_bytes(1'b1, 8, 72'h3938373635343332);
        chk("R4 frame after gaps", crc_tx, 32'hCBF43926);

        // R1: start wins over a same-cycle data bit.
        frame_start = 1'b1;
        lsb_first   = 1'b1;
        bit_valid   = 1'b1;
        bit_in      = 1'b1;
        tick();
        frame_start = 1'b0;
        bit_valid   = 1'b0;
        chk("R1 preset with bit", crc_run, 32'hFFFFFFFF);

        // R6: order input changed mid-frame is ignored.
        start_frame(1'b0);
        lsb_first = 1'b1;
        send_bytes(1'b0, 9, 72'h393837363534333231);
        chk("R6 order latched", crc_tx, 32'hFC891918);

        // R10: a trailing zero after message plus CRC fails the check.
        start_frame(1'b1);
        send_bytes(1'b1, 9, 72'h393837363534333231);
        send_crc(1'b1, 32'hCBF43926);
        send_bit(1'b0);
        end_frame();
        chk("R10 trailing zero fails", {30'd0, verdict_valid, verdict_pass}, 32'd2);

        // R10: a flipped CRC bit fails the check.
        start_frame(1'b0);
        send_bytes(1'b0, 9, 72'h393837363534333231);
        send_crc(1'b0, 32'hFC891918 ^ 32'h00010000);
        end_frame();
        chk("R10 corrupt crc fails", {30'd0, verdict_valid, verdict_pass}, 32'd2);

        // R10: a leading zero byte changes the CRC.
        start_frame(1'b1);
        send_byte(1'b1, 8'h00);
        send_byte(1'b1, 8'h61);
        got = crc_tx;
        chk_ne("R10 leading zeros", got, 32'hE8B7BE43);

        // R7: end strobe in the same cycle as the last CRC bit.
        start_frame(1'b1);
        send_byte(1'b1, 8'h61);
        for (int i = 0; i < 31; i++) send_bit(got[i] ^ got[i] ^ (32'hE8B7BE43 >> i) & 1'b1);
        frame_end = 1'b1;
        send_bit(1'b1);
        frame_end = 1'b0;
        chk("R7 end with last bit", {30'd0, verdict_valid, verdict_pass}, 32'd3);

        // R8: start and end together leave the verdict cleared.
        frame_start = 1'b1;
        frame_end   = 1'b1;
        tick();
        frame_start = 1'b0;
        frame_end   = 1'b0;
        chk("R8 start beats end", {30'd0, verdict_valid, verdict_pass}, 32'd0);

        // R9: reset in mid-frame.
        start_frame(1'b1);
        send_byte(1'b1, 8'h5A);
        end_frame();
        rst_n = 1'b0;
        tick();
        chk("R9 mid-frame reset crc", crc_run, 32'hFFFFFFFF);
        chk("R9 mid-frame reset verdict", {30'd0, verdict_valid, verdict_pass}, 32'd0);
        rst_n = 1'b1;
        tick();
        send_byte(1'b0, 8'h61);
        start_frame(1'b0);
        send_bytes(1'b0, 9, 72'h393837363534333231);
        chk("R9 order back to MSB-first", crc_tx, 32'hFC891918);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule